// File: doc/BRIEF.md
# Power-up configuration sequencer

This controller steps a programmable device from power-on to user operation. A free-running timer tick paces it, and it passes through these phases: a power-on wait, a configuration-memory wipe, a final check of reset and the mode pins, the configuration load, a short start-up, and user operation. The power-on wait is four times longer when the mode pins select a mode in which the device drives the configuration clock. The longer wait lets slower downstream devices finish their own initialization before loading starts.

The active-low `init_no` output behaves like an open-drain flag. It is held low until the wipe has finished. It also goes low when the loader reports a missing stop bit, and when the mode pins carry a reserved code. An external reset held low for `ABORT_TICKS` ticks during loading aborts the load and restarts the wipe. After every wipe the mode pins are sampled again. In user operation, reset and the reprogram request held low together start a new configuration cycle.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `init_no`=0, `io_tri_o`=1, `io_pu_o`=1, `clr_mem_o`=0 and `cclk_out_o`=0.
- R2: The power-on wait lasts `POR_SHORT_TICKS` ticks for mode codes 001, 100, 101, 110 and 111. It lasts 4×`POR_SHORT_TICKS` ticks for the master codes 000, 010 and 011. `clr_mem_o` rises only after that many ticks.
- R3: The wipe holds `clr_mem_o`=1 and `init_no`=0 for `CLEAR_TICKS` ticks. When that count completes, both are released.
- R4: After the wipe, the controller stays put while `ext_rst_ni` is low, and `mode_o` keeps its previous value. Once `ext_rst_ni` is high, `mode_i` is captured into `mode_o`. A reserved code (001, 100, 110) drives `init_no` low and starts no load.
- R5: `cclk_out_o`=1 only for a captured master code while loading, starting up or operating. Peripheral code 101 and slave code 111 give 0.
- R6: While loading, `ext_rst_ni` low for `ABORT_TICKS` consecutive ticks returns the controller to the wipe (`clr_mem_o`=1). A shorter low pulse has no effect.
- R7: `stop_err_i` high while loading drives `init_no` low and halts the load; a later `cfg_done_i` is ignored.
- R8: `cfg_done_i` while loading starts a start-up of `STARTUP_TICKS` ticks, after which `io_tri_o` and `io_pu_o` go to 0.
- R9: In operation, `reprog_ni` and `ext_rst_ni` low together return the controller to the wipe. Either one low alone is ignored.
- R10: The reserved-mode and stop-bit error states are left only when `reprog_ni` and `ext_rst_ni` are low together, which starts a wipe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | Single-cycle internal timer tick |
| ext_rst_ni | input | 1 | External active-low reset pin |
| reprog_ni | input | 1 | Active-low reprogram request |
| mode_i | input | 3 | Mode pins |
| cfg_done_i | input | 1 | Loader reports configuration complete |
| stop_err_i | input | 1 | Loader reports a missing stop bit |
| init_no | output | 1 | Active-low initialization/error flag |
| clr_mem_o | output | 1 | Configuration memory wipe strobe |
| cclk_out_o | output | 1 | 1: device drives configuration clock |
| mode_o | output | 3 | Captured mode code |
| io_tri_o | output | 1 | Tristate user I/O |
| io_pu_o | output | 1 | Enable weak pull-ups on user I/O |

## Verification
All eight mode codes are tried from power-up. The power-on tick count separates master codes from the others. The post-wipe outcome separates reserved codes, which show `init_no` low, from loadable ones, which show the captured code and the clock direction. Directed runs hold external reset across the end of the wipe to show that capture waits for it and picks up a changed code. Reset pulses of two and three ticks inside loading mark the abort threshold. Single and paired lows on reset and reprogram, in operation and in the error state, show that only the pair restarts the sequence.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_POR, ST_CLEAR, ST_LOAD, ST_START, ST_OPER, ST_ERR
  } cfg_state_e;
endpackage

// File: rtl/cfg_mode_dec.sv
module cfg_mode_dec #(
  parameter logic [7:0] MASTER_SET   = 8'b0000_1101,
  parameter logic [7:0] RESERVED_SET = 8'b0101_0010
) (
  input  logic [2:0] mode_i,
  output logic       master_o,
  output logic       reserved_o
);
  assign master_o   = MASTER_SET[mode_i];
  assign reserved_o = RESERVED_SET[mode_i];
endmodule

// File: rtl/cfg_tick_cnt.sv
module cfg_tick_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] lim_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  // >= keeps hit stable if the limit drops below the count
  assign hit_o = (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (tick_i && !hit_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int POR_SHORT_TICKS = 16384,
  parameter int MASTER_MULT     = 4,
  parameter int CLEAR_TICKS     = 200,
  parameter int ABORT_TICKS     = 3,
  parameter int STARTUP_TICKS   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       ext_rst_ni,
  input  logic       reprog_ni,
  input  logic [2:0] mode_i,
  input  logic       cfg_done_i,
  input  logic       stop_err_i,
  output logic       init_no,
  output logic       clr_mem_o,
  output logic       cclk_out_o,
  output logic [2:0] mode_o,
  output logic       io_tri_o,
  output logic       io_pu_o
);
  localparam int POR_LONG_TICKS = POR_SHORT_TICKS * MASTER_MULT;
  localparam int PW = $clog2(POR_LONG_TICKS + 1);
  localparam int AW = $clog2(ABORT_TICKS + 1);

  cfg_state_e state_q, state_d;
  logic [2:0] mode_q, mode_d;
  logic       master_q, master_d;
  logic       live_master, live_reserved;
  logic       ph_hit, ab_hit;
  logic [PW-1:0] ph_lim;
  logic       both_low, running;

  cfg_mode_dec u_dec (
    .mode_i    (mode_i),
    .master_o  (live_master),
    .reserved_o(live_reserved)
  );

  always_comb begin
    unique case (state_q)
      ST_POR:   ph_lim = live_master ? PW'(POR_LONG_TICKS) : PW'(POR_SHORT_TICKS);
      ST_CLEAR: ph_lim = PW'(CLEAR_TICKS);
      ST_START: ph_lim = PW'(STARTUP_TICKS);
      default:  ph_lim = '0;
    endcase
  end

  // phase counter restarts on every state change
  cfg_tick_cnt #(.W(PW)) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_d != state_q),
    .tick_i(tick_i),
    .lim_i (ph_lim),
    .hit_o (ph_hit)
  );

  // abort counter: consecutive ticks of external reset low while loading
  cfg_tick_cnt #(.W(AW)) u_abort (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ext_rst_ni || (state_q != ST_LOAD)),
    .tick_i(tick_i),
    .lim_i (AW'(ABORT_TICKS)),
    .hit_o (ab_hit)
  );

  assign both_low = !reprog_ni && !ext_rst_ni;

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    master_d = master_q;
    unique case (state_q)
      ST_POR:   if (ph_hit) state_d = ST_CLEAR;
      ST_CLEAR: if (ph_hit && ext_rst_ni) begin
        mode_d   = mode_i;
        master_d = live_master;
        state_d  = live_reserved ? ST_ERR : ST_LOAD;
      end
      ST_LOAD: begin
        if (stop_err_i)      state_d = ST_ERR;
        else if (ab_hit)     state_d = ST_CLEAR;
        else if (cfg_done_i) state_d = ST_START;
      end
      ST_START: if (ph_hit) state_d = ST_OPER;
      ST_OPER,
      ST_ERR:   if (both_low) state_d = ST_CLEAR;
      default:  state_d = ST_POR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_POR;
      mode_q   <= '0;
      master_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      master_q <= master_d;
    end
  end

  assign running    = (state_q == ST_LOAD) || (state_q == ST_START) || (state_q == ST_OPER);
  assign clr_mem_o  = (state_q == ST_CLEAR) && !ph_hit;
  assign init_no    = !((state_q == ST_POR) || (state_q == ST_ERR) || clr_mem_o);
  assign cclk_out_o = master_q && running;
  assign mode_o     = mode_q;
  assign io_tri_o   = (state_q != ST_OPER);
  assign io_pu_o    = (state_q != ST_OPER);
endmodule

// File: rtl/cfg_seq_ctrl_chk.sv
module cfg_seq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ext_rst_ni,
  input logic       reprog_ni,
  input logic       init_no,
  input logic       clr_mem_o,
  input logic       cclk_out_o,
  input logic [2:0] mode_o,
  input logic       io_tri_o,
  input logic       io_pu_o
);
  assert_init_low_in_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_mem_o |-> !init_no);

  assert_cclk_needs_init_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_out_o |-> init_no);

  assert_mode_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> ($past(init_no) && !$past(clr_mem_o) && $past(io_tri_o)));

  assert_oper_init_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_tri_o |-> (init_no && !io_pu_o && !clr_mem_o));

  assert_oper_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!io_tri_o) && io_tri_o) |-> (clr_mem_o && $past(!reprog_ni && !ext_rst_ni)));
endmodule

bind cfg_seq_ctrl cfg_seq_ctrl_chk u_chk (.*);

// File: tb/cfg_seq_ctrl_tb.sv
module cfg_seq_ctrl_tb;
  localparam int POR_S = 8;
  localparam int POR_L = 32;
  localparam int CLR_T = 5;
  localparam int ABT_T = 3;
  localparam int STU_T = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic ext_rst_ni = 1'b1;
  logic reprog_ni = 1'b1;
  logic [2:0] mode_i = 3'd0;
  logic cfg_done_i = 1'b0;
  logic stop_err_i = 1'b0;
  logic init_no, clr_mem_o, cclk_out_o, io_tri_o, io_pu_o;
  logic [2:0] mode_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  cfg_seq_ctrl #(
    .POR_SHORT_TICKS(POR_S), .MASTER_MULT(4), .CLEAR_TICKS(CLR_T),
    .ABORT_TICKS(ABT_T), .STARTUP_TICKS(STU_T)
  ) u_dut (
    .clk_i, .rst_ni, .tick_i, .ext_rst_ni, .reprog_ni, .mode_i,
    .cfg_done_i, .stop_err_i, .init_no, .clr_mem_o, .cclk_out_o,
    .mode_o, .io_tri_o, .io_pu_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick1();
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic power_up(input logic [2:0] m, input logic ext);
    rst_ni = 1'b0; mode_i = m; ext_rst_ni = ext; reprog_ni = 1'b1;
    cfg_done_i = 1'b0; stop_err_i = 1'b0; tick_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic count_por(output int n);
    n = 0;
    while (!clr_mem_o && n < 200) begin tick1(); n++; end
  endtask

  task automatic count_clear(output int n);
    n = 0;
    while (clr_mem_o && n < 200) begin tick1(); n++; end
  endtask

  task automatic pulse_done();
    cfg_done_i = 1'b1; @(negedge clk_i); cfg_done_i = 1'b0;
  endtask

  function automatic bit is_master(input int m);
    return (m == 0) || (m == 2) || (m == 3);
  endfunction

  function automatic bit is_rsv(input int m);
    return (m == 1) || (m == 4) || (m == 6);
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int np, nc;
    // R1: reset state
    @(negedge clk_i);
    chk(!init_no && io_tri_o && io_pu_o && !clr_mem_o && !cclk_out_o, "R1 in reset",
        {init_no, io_tri_o, io_pu_o, clr_mem_o, cclk_out_o}, 5'b01100);

    // sweep of all mode codes
    for (int m = 0; m < 8; m++) begin
      power_up(3'(m), 1'b1);
      if (m == 0)
        chk(!init_no && io_tri_o && io_pu_o && !clr_mem_o && !cclk_out_o, "R1 after release",
            {init_no, io_tri_o, io_pu_o, clr_mem_o, cclk_out_o}, 5'b01100);
      count_por(np);
      chk(np == (is_master(m) ? POR_L : POR_S), "R2 power-on ticks", np, is_master(m) ? POR_L : POR_S);
      chk(!init_no, "R3 init low in clear", init_no, 0);
      count_clear(nc);
      chk(nc == CLR_T, "R3 clear ticks", nc, CLR_T);
      if (is_rsv(m)) begin
        chk(!init_no && !cclk_out_o, "R4 reserved code flags init", init_no, 0);
        reprog_ni = 1'b0; ticks(2);
        chk(!init_no && !clr_mem_o, "R10 reprog alone ignored", clr_mem_o, 0);
        reprog_ni = 1'b1; ext_rst_ni = 1'b0; ticks(4);
        chk(!init_no && !clr_mem_o, "R10 ext reset alone ignored", clr_mem_o, 0);
        reprog_ni = 1'b0; @(negedge clk_i);
        chk(clr_mem_o == 1'b1, "R10 both low restarts wipe", clr_mem_o, 1);
        reprog_ni = 1'b1; ext_rst_ni = 1'b1;
      end else begin
        chk(init_no && mode_o == 3'(m), "R4 mode captured", mode_o, m);
        chk(cclk_out_o == is_master(m), "R5 clock direction", cclk_out_o, is_master(m));
        pulse_done();
        ticks(STU_T - 1);
        chk(io_tri_o == 1'b1, "R8 still starting", io_tri_o, 1);
        tick1();
        chk(!io_tri_o && !io_pu_o, "R8 operational io release", {io_tri_o, io_pu_o}, 0);
      end
    end

    // capture waits for external reset; resample after abort
    power_up(3'd7, 1'b0);
    count_por(np);
    chk(np == POR_S, "R2 slave power-on ticks", np, POR_S);
    count_clear(nc);
    chk(nc == CLR_T, "R3 clear under held reset", nc, CLR_T);
    chk(init_no == 1'b1, "R3 init released after clear", init_no, 1);
    mode_i = 3'd5;
    ticks(3);
    chk(mode_o == 3'd0 && !cclk_out_o, "R4 held while reset low", mode_o, 0);
    ext_rst_ni = 1'b1; repeat (2) @(negedge clk_i);
    chk(mode_o == 3'd5 && !cclk_out_o, "R4 peripheral captured", mode_o, 5);

    ext_rst_ni = 1'b0; ticks(ABT_T - 1); ext_rst_ni = 1'b1; tick1();
    chk(!clr_mem_o && init_no, "R6 short reset no abort", clr_mem_o, 0);
    ext_rst_ni = 1'b0; ticks(ABT_T);
    chk(clr_mem_o == 1'b1, "R6 abort to wipe", clr_mem_o, 1);
    ext_rst_ni = 1'b1; mode_i = 3'd2;
    count_clear(nc);
    chk(nc == CLR_T, "R3 clear after abort", nc, CLR_T);
    chk(mode_o == 3'd2 && cclk_out_o, "R4 resample master code", mode_o, 2);

    // stop-bit error
    stop_err_i = 1'b1; @(negedge clk_i); stop_err_i = 1'b0;
    chk(!init_no && !cclk_out_o, "R7 stop error flags init", init_no, 0);
    pulse_done(); ticks(STU_T + 1);
    chk(io_tri_o && !init_no, "R7 load halted", io_tri_o, 1);
    ext_rst_ni = 1'b0; reprog_ni = 1'b0; @(negedge clk_i);
    chk(clr_mem_o == 1'b1, "R10 error exit to wipe", clr_mem_o, 1);
    ext_rst_ni = 1'b1; reprog_ni = 1'b1;
    count_clear(nc);
    pulse_done(); ticks(STU_T);
    chk(!io_tri_o, "R8 operational after recovery", io_tri_o, 0);

    // operation: single lows ignored, pair restarts
    reprog_ni = 1'b0; ticks(2);
    chk(!io_tri_o && !clr_mem_o, "R9 reprog alone ignored", io_tri_o, 0);
    reprog_ni = 1'b1; ext_rst_ni = 1'b0; ticks(ABT_T + 1);
    chk(!io_tri_o && !clr_mem_o, "R9 ext reset alone ignored", io_tri_o, 0);
    reprog_ni = 1'b0; @(negedge clk_i);
    chk(clr_mem_o && io_tri_o && !init_no, "R9 pair restarts wipe", clr_mem_o, 1);
    reprog_ni = 1'b1; ext_rst_ni = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule